// File: doc/BRIEF.md
# CAN Controller SPI Register Front End

This block is the SPI slave face of a small CAN controller. Every chip-select frame begins with a one-byte opcode. The opcode then selects what the frame does. It can write the next byte into a configuration register. It can return a register on the next byte. It can trigger a master reset on its own. It can stream bytes to or from a neighbouring message FIFO. The configuration registers hold the operating mode, transmit enable, interrupt enable and two bit-timing bytes. The block decodes these registers into ready-to-use fields for the protocol engine.

The protocol engine drives three side-band registers. The status register is loaded on a strobe and comes out of reset as 0x82. The interrupt-flag and error-flag registers collect single-cycle set pulses. Both clear when software reads them. The receive and transmit error counters are read straight from engine inputs. The SPI pins are sampled with the system clock, so the SCK half period must span several clock cycles.

Top module: `can_spi_regif`

## Requirements
- R1: After `rst_n`, CTRL0 holds 0x80 (mode 4, init). CTRL1, BTR0, BTR1 and interrupt enable hold 0x00, and status holds 0x82. MISO is low while chip select is high.
- R2: A frame made of a write opcode and a data byte stores the data byte. The write opcodes are 0x14 CTRL0, 0x16 CTRL1, 0x18 BTR0, 0x1A BTR1 and 0x1C interrupt enable (driven on `cfg_int_en`).
- R3: A frame made of a read opcode and one more byte returns the register on MISO, MSB first, during the second byte. SPI is mode 0: MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. The read opcodes are 0xD2 CTRL0, 0xD4 CTRL1, 0xD6 BTR0, 0xD8 BTR1, 0xE2 status, 0xEA `rec_in` and 0xEC `tec_in`.
- R4: The block decodes the configuration as follows. Mode is CTRL0[7:5] (0 normal, 1 loopback, 2 monitor, 3 sleep, 4 init). Transmit enable is CTRL1[7]. SJW is BTR0[7:6]+1 and the prescaler is BTR0[5:0]+1. The triple-sample flag is BTR1[7]. TSEG2 is BTR1[6:4]+1 and TSEG1 is BTR1[3:0]+1.
- R5: The one-byte opcode 0x56 restores the R1 values and clears the interrupt flags. It leaves the error flags unchanged.
- R6: The error flags gather `err_set` pulses. Opcode 0xDC returns the flags and clears them.
- R7: The interrupt flags gather `int_set` pulses. Opcode 0xDE returns the flags and clears them. A set pulse in the clearing cycle is not in the returned value and stays pending.
- R8: A `stat_upd` pulse loads `stat_in` into the status register.
- R9: An unknown opcode changes no register and returns 0x00 on MISO.
- R10: Raising chip select mid-frame discards the partial frame with no effect. The next frame starts again with an opcode.
- R11: After opcode 0x12, each complete following byte appears on `fifo_wr_data` with a one-cycle `fifo_wr_valid`.
- R12: After opcode 0x48, the following bytes return successive `fifo_rd_data` values. Each completed data byte issues one `fifo_rd_take` pulse.
- R13: In register frames, bytes after the second byte are ignored and read back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data in |
| spi_miso | output | 1 | SPI data out |
| stat_upd | input | 1 | Load strobe for the status register |
| stat_in | input | 8 | New status value |
| int_set | input | 8 | Interrupt flag set pulses |
| err_set | input | 8 | Error flag set pulses |
| rec_in | input | 8 | Receive error counter |
| tec_in | input | 8 | Transmit error counter |
| fifo_wr_valid | output | 1 | One-cycle strobe for a byte going to the message FIFO |
| fifo_wr_data | output | 8 | Byte going to the message FIFO |
| fifo_rd_take | output | 1 | Head byte of the message FIFO consumed |
| fifo_rd_data | input | 8 | Head byte of the message FIFO |
| cfg_mode | output | 3 | Operating mode |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_int_en | output | 8 | Interrupt enable mask |
| cfg_triple | output | 1 | Three samples per bit |
| cfg_sjw | output | 3 | Sync jump width, 1..4 |
| cfg_brp | output | 7 | Baud prescaler, 1..64 |
| cfg_tseg1 | output | 5 | Time segment 1, 1..16 |
| cfg_tseg2 | output | 4 | Time segment 2, 1..8 |

## Verification
A bit counter or frame phase that is out of step shows up at the ports in the next frame. Either the data byte is taken as an opcode, or a read returns a shifted value. The decoded configuration outputs and the read-back bytes then differ from the model within one transfer. A flag register that clears at the wrong cycle is caught by the following read. It either loses the pulse injected into the clearing cycle, or it returns the pulse twice. The FIFO streaming counters are compared at the end of each frame.

// File: rtl/can_spi_regif_pkg.sv
package can_spi_regif_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // opcode values
  localparam byte_t OP_MRESET = 8'h56;
  localparam byte_t OP_WR_C0  = 8'h14;
  localparam byte_t OP_RD_C0  = 8'hD2;
  localparam byte_t OP_WR_C1  = 8'h16;
  localparam byte_t OP_RD_C1  = 8'hD4;
  localparam byte_t OP_WR_T0  = 8'h18;
  localparam byte_t OP_RD_T0  = 8'hD6;
  localparam byte_t OP_WR_T1  = 8'h1A;
  localparam byte_t OP_RD_T1  = 8'hD8;
  localparam byte_t OP_WR_IE  = 8'h1C;
  localparam byte_t OP_RD_IF  = 8'hDE;
  localparam byte_t OP_RD_EF  = 8'hDC;
  localparam byte_t OP_RD_ST  = 8'hE2;
  localparam byte_t OP_RD_REC = 8'hEA;
  localparam byte_t OP_RD_TEC = 8'hEC;
  localparam byte_t OP_FIFO_W = 8'h12;
  localparam byte_t OP_FIFO_R = 8'h48;

  localparam byte_t CTRL0_RST = 8'h80;  // init mode in bits 7:5
  localparam byte_t STAT_RST  = 8'h82;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_C0, SEL_C1, SEL_T0, SEL_T1, SEL_IE,
    SEL_IF, SEL_EF, SEL_ST, SEL_REC, SEL_TEC
  } reg_sel_e;

  typedef enum logic [2:0] {
    K_NONE, K_RESET, K_WRITE, K_READ, K_FWR, K_FRD
  } op_kind_e;

  typedef enum logic [2:0] {
    PH_OP, PH_WDATA, PH_FWR, PH_FRD, PH_SKIP
  } phase_e;

  typedef struct packed {
    op_kind_e kind;
    reg_sel_e sel;
  } op_dec_t;

  function automatic op_dec_t decode_op(byte_t op);
    op_dec_t d;
    d = '{kind: K_NONE, sel: SEL_NONE};
    case (op)
      OP_MRESET: d.kind = K_RESET;
      OP_WR_C0:  d = '{kind: K_WRITE, sel: SEL_C0};
      OP_WR_C1:  d = '{kind: K_WRITE, sel: SEL_C1};
      OP_WR_T0:  d = '{kind: K_WRITE, sel: SEL_T0};
      OP_WR_T1:  d = '{kind: K_WRITE, sel: SEL_T1};
      OP_WR_IE:  d = '{kind: K_WRITE, sel: SEL_IE};
      OP_RD_C0:  d = '{kind: K_READ, sel: SEL_C0};
      OP_RD_C1:  d = '{kind: K_READ, sel: SEL_C1};
      OP_RD_T0:  d = '{kind: K_READ, sel: SEL_T0};
      OP_RD_T1:  d = '{kind: K_READ, sel: SEL_T1};
      OP_RD_IF:  d = '{kind: K_READ, sel: SEL_IF};
      OP_RD_EF:  d = '{kind: K_READ, sel: SEL_EF};
      OP_RD_ST:  d = '{kind: K_READ, sel: SEL_ST};
      OP_RD_REC: d = '{kind: K_READ, sel: SEL_REC};
      OP_RD_TEC: d = '{kind: K_READ, sel: SEL_TEC};
      OP_FIFO_W: d.kind = K_FWR;
      OP_FIFO_R: d.kind = K_FRD;
      default:   d.kind = K_NONE;
    endcase
    return d;
  endfunction

  // bit-timing field arithmetic: stored values are "minus one"
  function automatic logic [2:0] sjw_of(byte_t t0);
    return 3'(t0[7:6]) + 3'd1;
  endfunction
  function automatic logic [6:0] brp_of(byte_t t0);
    return 7'(t0[5:0]) + 7'd1;
  endfunction
  function automatic logic [4:0] tseg1_of(byte_t t1);
    return 5'(t1[3:0]) + 5'd1;
  endfunction
  function automatic logic [3:0] tseg2_of(byte_t t1);
    return 4'(t1[6:4]) + 4'd1;
  endfunction

endpackage

// File: rtl/can_spi_regif_link.sv
module can_spi_regif_link #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spi_sck,
  input  logic         spi_cs_n,
  input  logic         spi_mosi,
  output logic         spi_miso,
  output logic         frame_idle,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  input  logic         tx_load,
  input  logic [W-1:0] tx_data
);
  localparam int CW = $clog2(W);

  // {mosi, cs_n, sck}
  logic [2:0] sync_q [SYNC_STAGES];
  logic       sck_s, cs_s, mosi_s, sck_q;
  logic       rise, fall;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= 3'b010;
    end else begin
      sync_q[0] <= {spi_mosi, spi_cs_n, spi_sck};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign sck_s  = sync_q[SYNC_STAGES-1][0];
  assign cs_s   = sync_q[SYNC_STAGES-1][1];
  assign mosi_s = sync_q[SYNC_STAGES-1][2];
  assign rise   = sck_s & ~sck_q;
  assign fall   = ~sck_s & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sck_q     <= sck_s;
      byte_done <= 1'b0;
      if (cs_s) begin
        cnt_q <= '0;
        tx_q  <= '0;
      end else begin
        if (rise) begin
          rx_q  <= {rx_q[W-2:0], mosi_s};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(W-1)) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_q[W-2:0], mosi_s};
          end
        end
        // first fall after a byte boundary keeps the freshly loaded MSB
        if (tx_load) tx_q <= tx_data;
        else if (fall && cnt_q != '0) tx_q <= {tx_q[W-2:0], 1'b0};
      end
    end
  end

  assign spi_miso   = tx_q[W-1];
  assign frame_idle = cs_s;
endmodule

// File: rtl/can_spi_regif_regs.sv
module can_spi_regif_regs
  import can_spi_regif_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mreset,
  input  logic     wr_en,
  input  reg_sel_e wr_sel,
  input  byte_t    wr_data,
  input  reg_sel_e rd_sel,
  input  logic     rd_strobe,
  input  logic     stat_upd,
  input  byte_t    stat_in,
  input  byte_t    int_set,
  input  byte_t    err_set,
  input  byte_t    rec_in,
  input  byte_t    tec_in,
  output byte_t    ctrl0,
  output byte_t    ctrl1,
  output byte_t    btr0,
  output byte_t    btr1,
  output byte_t    inte,
  output byte_t    stat,
  output byte_t    intf,
  output byte_t    errf,
  output byte_t    rd_val,
  output logic     int_clr,
  output logic     err_clr
);
  assign int_clr = rd_strobe && rd_sel == SEL_IF;
  assign err_clr = rd_strobe && rd_sel == SEL_EF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0 <= CTRL0_RST; ctrl1 <= '0; btr0 <= '0; btr1 <= '0; inte <= '0;
      stat  <= STAT_RST;  intf  <= '0; errf <= '0;
    end else begin
      if (mreset) begin
        ctrl0 <= CTRL0_RST; ctrl1 <= '0; btr0 <= '0; btr1 <= '0; inte <= '0;
        stat  <= STAT_RST;
        intf  <= int_set;
      end else begin
        if (wr_en) begin
          case (wr_sel)
            SEL_C0:  ctrl0 <= wr_data;
            SEL_C1:  ctrl1 <= wr_data;
            SEL_T0:  btr0  <= wr_data;
            SEL_T1:  btr1  <= wr_data;
            SEL_IE:  inte  <= wr_data;
            default: ;
          endcase
        end
        if (stat_upd) stat <= stat_in;
        intf <= (int_clr ? '0 : intf) | int_set;
      end
      errf <= (err_clr ? '0 : errf) | err_set;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_C0:  rd_val = ctrl0;
      SEL_C1:  rd_val = ctrl1;
      SEL_T0:  rd_val = btr0;
      SEL_T1:  rd_val = btr1;
      SEL_IF:  rd_val = intf;
      SEL_EF:  rd_val = errf;
      SEL_ST:  rd_val = stat;
      SEL_REC: rd_val = rec_in;
      SEL_TEC: rd_val = tec_in;
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/can_spi_regif.sv
module can_spi_regif
  import can_spi_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       stat_upd,
  input  logic [7:0] stat_in,
  input  logic [7:0] int_set,
  input  logic [7:0] err_set,
  input  logic [7:0] rec_in,
  input  logic [7:0] tec_in,
  output logic       fifo_wr_valid,
  output logic [7:0] fifo_wr_data,
  output logic       fifo_rd_take,
  input  logic [7:0] fifo_rd_data,
  output logic [2:0] cfg_mode,
  output logic       cfg_tx_en,
  output logic [7:0] cfg_int_en,
  output logic       cfg_triple,
  output logic [2:0] cfg_sjw,
  output logic [6:0] cfg_brp,
  output logic [4:0] cfg_tseg1,
  output logic [3:0] cfg_tseg2
);
  // named internal events, observed by the bound checker
  logic     frame_idle, byte_done, tx_load, rd_strobe, wr_en, mreset_evt;
  logic     reload_q, int_clr, err_clr;
  byte_t    rx_byte, tx_data, rd_val;
  byte_t    ctrl0, ctrl1, btr0, btr1, inte, stat, intf, errf;
  reg_sel_e rd_sel, wsel_q, wsel_nxt;
  phase_e   phase_q, phase_nxt;
  op_dec_t  dec;

  can_spi_regif_link #(.W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) link_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .frame_idle(frame_idle),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load), .tx_data(tx_data)
  );

  can_spi_regif_regs regs_i (
    .clk(clk), .rst_n(rst_n), .mreset(mreset_evt), .wr_en(wr_en), .wr_sel(wsel_q),
    .wr_data(rx_byte), .rd_sel(rd_sel), .rd_strobe(rd_strobe), .stat_upd(stat_upd),
    .stat_in(stat_in), .int_set(int_set), .err_set(err_set), .rec_in(rec_in),
    .tec_in(tec_in), .ctrl0(ctrl0), .ctrl1(ctrl1), .btr0(btr0), .btr1(btr1),
    .inte(inte), .stat(stat), .intf(intf), .errf(errf), .rd_val(rd_val),
    .int_clr(int_clr), .err_clr(err_clr)
  );

  assign dec = decode_op(rx_byte);

  always_comb begin
    tx_load       = 1'b0;
    tx_data       = '0;
    rd_strobe     = 1'b0;
    rd_sel        = SEL_NONE;
    wr_en         = 1'b0;
    mreset_evt    = 1'b0;
    fifo_wr_valid = 1'b0;
    fifo_rd_take  = 1'b0;
    phase_nxt     = phase_q;
    wsel_nxt      = wsel_q;
    if (reload_q) begin
      tx_load = 1'b1;
      tx_data = fifo_rd_data;
    end
    if (byte_done) begin
      case (phase_q)
        PH_OP: begin
          tx_load   = 1'b1;
          phase_nxt = PH_SKIP;
          case (dec.kind)
            K_RESET: mreset_evt = 1'b1;
            K_WRITE: begin wsel_nxt = dec.sel; phase_nxt = PH_WDATA; end
            K_READ:  begin rd_sel = dec.sel; rd_strobe = 1'b1; tx_data = rd_val; end
            K_FWR:   phase_nxt = PH_FWR;
            K_FRD:   begin tx_data = fifo_rd_data; phase_nxt = PH_FRD; end
            default: ;
          endcase
        end
        PH_WDATA: begin tx_load = 1'b1; wr_en = 1'b1; phase_nxt = PH_SKIP; end
        PH_FWR:   begin tx_load = 1'b1; fifo_wr_valid = 1'b1; end
        PH_FRD:   fifo_rd_take = 1'b1;
        default:  tx_load = 1'b1;
      endcase
    end
    if (frame_idle) phase_nxt = PH_OP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_OP;
      wsel_q   <= SEL_NONE;
      reload_q <= 1'b0;
    end else begin
      phase_q  <= phase_nxt;
      wsel_q   <= wsel_nxt;
      reload_q <= fifo_rd_take && !frame_idle;
    end
  end

  assign fifo_wr_data = rx_byte;
  assign cfg_mode     = ctrl0[7:5];
  assign cfg_tx_en    = ctrl1[7];
  assign cfg_int_en   = inte;
  assign cfg_triple   = btr1[7];
  assign cfg_sjw      = sjw_of(btr0);
  assign cfg_brp      = brp_of(btr0);
  assign cfg_tseg1    = tseg1_of(btr1);
  assign cfg_tseg2    = tseg2_of(btr1);
endmodule

// File: rtl/can_spi_regif_chk.sv
module can_spi_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_idle,
  input logic       spi_miso,
  input logic       mreset_evt,
  input logic [2:0] cfg_mode,
  input logic       stat_upd,
  input logic [7:0] stat_in,
  input logic [7:0] stat,
  input logic       int_clr,
  input logic [7:0] int_set,
  input logic [7:0] intf,
  input logic       err_clr,
  input logic [7:0] err_set,
  input logic [7:0] errf,
  input logic       fifo_wr_valid,
  input logic       fifo_rd_take,
  input logic       tx_load
);
  a_r1_miso_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idle |=> !spi_miso);

  a_r5_init_mode_after_mreset: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_evt |=> cfg_mode == 3'd4);

  a_r6_err_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> errf == $past(err_set));

  a_r7_int_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr |=> intf == $past(int_set));

  a_r8_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd && !mreset_evt |=> stat == $past(stat_in));

  a_r11_wr_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |=> !fifo_wr_valid);

  a_r12_take_then_reload: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_take && !frame_idle |=> tx_load);
endmodule

bind can_spi_regif can_spi_regif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_idle(frame_idle), .spi_miso(spi_miso),
  .mreset_evt(mreset_evt), .cfg_mode(cfg_mode), .stat_upd(stat_upd),
  .stat_in(stat_in), .stat(stat), .int_clr(int_clr), .int_set(int_set),
  .intf(intf), .err_clr(err_clr), .err_set(err_set), .errf(errf),
  .fifo_wr_valid(fifo_wr_valid), .fifo_rd_take(fifo_rd_take), .tx_load(tx_load)
);

// File: tb/can_spi_regif_tb_top.sv
module can_spi_regif_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic stat_upd = 1'b0;
  logic [7:0] stat_in = '0, int_set = '0, err_set = '0, rec_in = '0, tec_in = '0;
  logic fifo_wr_valid, fifo_rd_take;
  logic [7:0] fifo_wr_data, fifo_rd_data, cfg_int_en;
  logic [2:0] cfg_mode, cfg_sjw;
  logic cfg_tx_en, cfg_triple;
  logic [6:0] cfg_brp;
  logic [4:0] cfg_tseg1;
  logic [3:0] cfg_tseg2;

  always #5 clk = ~clk;

  can_spi_regif dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .stat_upd(stat_upd), .stat_in(stat_in), .int_set(int_set),
    .err_set(err_set), .rec_in(rec_in), .tec_in(tec_in),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
    .fifo_rd_take(fifo_rd_take), .fifo_rd_data(fifo_rd_data),
    .cfg_mode(cfg_mode), .cfg_tx_en(cfg_tx_en), .cfg_int_en(cfg_int_en),
    .cfg_triple(cfg_triple), .cfg_sjw(cfg_sjw), .cfg_brp(cfg_brp),
    .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2)
  );

  int checks = 0, errors = 0;
  bit settled = 1'b0, finished = 1'b0;
  // reference model
  int m_c0 = 128, m_c1 = 0, m_t0 = 0, m_t1 = 0, m_ie = 0;
  int m_st = 130, m_if = 0, m_ef = 0;
  int takes = 0;
  logic [7:0] fwr_q[$];
  logic [7:0] tx_b [8];
  logic [7:0] rx_b [8];
  logic [7:0] inj_mask = '0;

  assign fifo_rd_data = 8'hA0 + 8'(takes);

  always @(posedge clk) begin
    if (fifo_wr_valid) fwr_q.push_back(fifo_wr_data);
    if (fifo_rd_take) takes++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // decoded outputs against the model on every settled clock
  always @(negedge clk) begin
    if (settled && rst_n && !finished) begin
      chk("R4 mode",  int'(cfg_mode),   m_c0 / 32);
      chk("R4 txen",  int'(cfg_tx_en),  m_c1 / 128);
      chk("R2 inten", int'(cfg_int_en), m_ie);
      chk("R4 sjw",   int'(cfg_sjw),    m_t0 / 64 + 1);
      chk("R4 brp",   int'(cfg_brp),    m_t0 % 64 + 1);
      chk("R4 trip",  int'(cfg_triple), m_t1 / 128);
      chk("R4 tseg2", int'(cfg_tseg2),  (m_t1 / 16) % 8 + 1);
      chk("R4 tseg1", int'(cfg_tseg1),  m_t1 % 16 + 1);
    end
  end

  task automatic frame(input int nbits);
    settled = 1'b0;
    for (int b = 0; b < 8; b++) rx_b[b] = 8'h00;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx_b[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      rx_b[i/8][7-(i%8)] = miso;
      sck = 1'b1;
      if (i == 7 && inj_mask != 8'h00) begin
        // pulse lands in the cycle the read clears the flags
        repeat (3) @(negedge clk);
        int_set = inj_mask;
        @(negedge clk);
        int_set = 8'h00;
        repeat (HALF-4) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    settled = 1'b1;
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] d);
    tx_b[0] = op; tx_b[1] = d;
    frame(16);
  endtask

  task automatic rd(input logic [7:0] op, output int v);
    tx_b[0] = op; tx_b[1] = 8'h00;
    frame(16);
    v = int'(rx_b[1]);
  endtask

  task automatic pulse_int(input logic [7:0] m);
    int_set = m; @(negedge clk); int_set = 8'h00; @(negedge clk);
    m_if = m_if | int'(m);
  endtask

  task automatic pulse_err(input logic [7:0] m);
    err_set = m; @(negedge clk); err_set = 8'h00; @(negedge clk);
    m_ef = m_ef | int'(m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", int'(cfg_mode), 4);
    chk("R1 txen", int'(cfg_tx_en), 0);
    chk("R1 brp", int'(cfg_brp), 1);
    chk("R1 miso", int'(miso), 0);
    settled = 1'b1;
    rd(8'hE2, v); chk("R1 status", v, 130);
    rd(8'hD2, v); chk("R1 ctrl0", v, 128);

    // R2/R3 writes and read-back, including field extremes for R4
    wr(8'h14, 8'h40); m_c0 = 64;
    wr(8'h16, 8'h80); m_c1 = 128;
    wr(8'h18, 8'hC5); m_t0 = 197;
    wr(8'h1A, 8'h7A); m_t1 = 122;
    wr(8'h1C, 8'h35); m_ie = 53;
    rd(8'hD2, v); chk("R3 ctrl0", v, m_c0);
    rd(8'hD4, v); chk("R3 ctrl1", v, m_c1);
    rd(8'hD6, v); chk("R3 btr0", v, m_t0);
    rd(8'hD8, v); chk("R3 btr1", v, m_t1);
    wr(8'h18, 8'h3F); m_t0 = 63;
    wr(8'h1A, 8'hFF); m_t1 = 255;
    rd(8'hD8, v); chk("R4 btr1 max", v, 255);
    wr(8'h14, 8'h60); m_c0 = 96;
    rec_in = 8'h5A; tec_in = 8'hA5;
    rd(8'hEA, v); chk("R3 rec", v, 90);
    rd(8'hEC, v); chk("R3 tec", v, 165);

    // R8 status load
    stat_in = 8'h14; stat_upd = 1'b1; @(negedge clk); stat_upd = 1'b0; m_st = 20;
    rd(8'hE2, v); chk("R8 status", v, m_st);

    // R6 error flags
    pulse_err(8'h21); pulse_err(8'h40);
    rd(8'hDC, v); chk("R6 err read", v, m_ef); m_ef = 0;
    rd(8'hDC, v); chk("R6 err cleared", v, 0);

    // R7 interrupt flags with a pulse in the clearing cycle
    pulse_int(8'h05);
    inj_mask = 8'h80;
    rd(8'hDE, v); chk("R7 int read", v, m_if);
    inj_mask = 8'h00; m_if = 128;
    rd(8'hDE, v); chk("R7 int kept", v, m_if); m_if = 0;
    rd(8'hDE, v); chk("R7 int cleared", v, 0);

    // R5 master reset
    pulse_int(8'h02); pulse_err(8'h08);
    tx_b[0] = 8'h56; frame(8);
    m_c0 = 128; m_c1 = 0; m_t0 = 0; m_t1 = 0; m_ie = 0; m_st = 130; m_if = 0;
    rd(8'hE2, v); chk("R5 status", v, 130);
    rd(8'hD2, v); chk("R5 ctrl0", v, 128);
    rd(8'hDE, v); chk("R5 int cleared", v, 0);
    rd(8'hDC, v); chk("R5 err kept", v, 8); m_ef = 0;

    // R9 unknown opcode
    wr(8'h77, 8'hFF); chk("R9 miso", int'(rx_b[1]), 0);
    rd(8'hD4, v); chk("R9 ctrl1 unchanged", v, 0);

    // R10 aborted frame, then a clean one
    wr(8'h16, 8'h80); m_c1 = 128;
    tx_b[0] = 8'h16; tx_b[1] = 8'h00; frame(13);
    rd(8'hD4, v); chk("R10 abort", v, 128);
    tx_b[0] = 8'h14; frame(5);
    rd(8'hD2, v); chk("R10 resync", v, m_c0);

    // R11 FIFO write stream
    tx_b[0] = 8'h12; tx_b[1] = 8'h11; tx_b[2] = 8'h22; tx_b[3] = 8'h33;
    frame(32);
    chk("R11 count", fwr_q.size(), 3);
    if (fwr_q.size() == 3) begin
      chk("R11 b0", int'(fwr_q[0]), 17);
      chk("R11 b2", int'(fwr_q[2]), 51);
    end

    // R12 FIFO read stream
    tx_b[0] = 8'h48; tx_b[1] = 8'h00; tx_b[2] = 8'h00; tx_b[3] = 8'h00;
    frame(32);
    chk("R12 b1", int'(rx_b[1]), 160);
    chk("R12 b2", int'(rx_b[2]), 161);
    chk("R12 b3", int'(rx_b[3]), 162);
    chk("R12 takes", takes, 3);

    // R13 trailing bytes
    tx_b[0] = 8'h16; tx_b[1] = 8'h00; tx_b[2] = 8'h80; frame(24); m_c1 = 0;
    tx_b[0] = 8'hD4; tx_b[1] = 8'h00; tx_b[2] = 8'h00; frame(24);
    chk("R13 value", int'(rx_b[1]), 0);
    chk("R13 trailing", int'(rx_b[2]), 0);
    wr(8'h16, 8'h80); m_c1 = 128;
    tx_b[0] = 8'hD4; tx_b[1] = 8'h00; tx_b[2] = 8'h00; frame(24);
    chk("R13 trailing after data", int'(rx_b[2]), 0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule